// File: doc/BRIEF.md
# Masked Sticky Error Status Aggregator

This block gathers single-cycle error pulses from the checkers of a received video stream and keeps them in a sticky status word, one bit per error condition. A programmable monitor mask decides which conditions may be latched. A single active-low flag goes LOW while any latched condition is present and goes HIGH again when the stream is clean.

Latched conditions stay set until one of two clear events. The first is a start-of-frame or start-of-field strobe. The second is a host read of the status word. A read returns the word as it stood before the clear. An error pulse that arrives in the same cycle as a clear still gets latched.

The host loads the mask through a simple write strobe with data. Everything runs on the pixel clock with a synchronous, active-high reset.

Top module: `err_status_agg`

## Requirements
- R1: While `rst` is high at a clock edge, the status word becomes 0 and the mask becomes all ones, so after that edge `statusData` is 0 and `errFlagN` is 1.
- R2: A one-cycle pulse on `errPulse[i]` with mask bit i set sets `statusData[i]` after that clock edge. The bit stays set on later edges until a clear event.
- R3: `errFlagN` is 0 exactly when at least one status bit is set and is 1 when the status word is 0. It changes on the same edge as the status word.
- R4: A `frameStart` high at a clock edge clears every status bit on that edge, apart from bits set by pulses in that same cycle.
- R5: During a cycle with `statusRead` high, `statusData` shows the latched word from before the clear. After that edge the word is cleared, apart from bits set by pulses in that same cycle.
- R6: When an error pulse and a clear event (frame start or read) fall in the same cycle, the pulsed monitored bits are set after the edge.
- R7: A pulse on a bit whose mask bit is 0 is ignored. It leaves that status bit at 0 and does not pull `errFlagN` low.
- R8: `maskWrEn` high at an edge loads `maskWrData` into the mask, with bit i of the mask enabling condition i. Pulses in that same cycle are filtered by the old mask. Pulses from the next cycle on are filtered by the new mask.
- R9: After reset, every one of the 8 conditions is monitored without any mask write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| errPulse | input | 8 | Per-condition error pulses, one cycle each |
| frameStart | input | 1 | Start of frame or field strobe, clears the status word |
| statusRead | input | 1 | Host read strobe for the status word, clears it |
| maskWrEn | input | 1 | Host write strobe for the mask |
| maskWrData | input | 8 | New mask value, 1 means monitored |
| statusData | output | 8 | Latched status word |
| errFlagN | output | 1 | Active-low summary flag, LOW while any latched error is present |

## Verification
Pulses, clears and mask writes all act on the next rising edge. The status word and the flag are therefore checked one edge after the cycle that carried the stimulus. The pre-clear value returned by a read is visible in the read cycle itself. The bench drives inputs on the falling edge and checks the read value before the following rising edge. It checks the updated word and flag shortly after that rising edge.

The bench sweeps every 8-bit pulse pattern and every single-bit mask. Its expected values come from a bitwise model of the requirements, computed separately from the design.

// File: rtl/err_agg_pkg.sv
package err_agg_pkg;
  localparam int ERR_W = 8;

  typedef struct packed {
    logic clearAll;
    logic loadMask;
  } errCtlT;
endpackage

// File: rtl/err_agg_ctrl.sv
module err_agg_ctrl
  import err_agg_pkg::*;
(
  input  logic   frameStart,
  input  logic   statusRead,
  input  logic   maskWrEn,
  output errCtlT ctl
);
  always_comb begin
    ctl.clearAll = frameStart | statusRead;
    ctl.loadMask = maskWrEn;
  end
endmodule

// File: rtl/err_agg_datapath.sv
module err_agg_datapath
  import err_agg_pkg::*;
#(
  parameter int WIDTH = ERR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  errCtlT           ctl,
  input  logic [WIDTH-1:0] errPulse,
  input  logic [WIDTH-1:0] maskWrData,
  output logic [WIDTH-1:0] statusData,
  output logic             errFlagN
);
  localparam logic [WIDTH-1:0] ALL_ON = {WIDTH{1'b1}};

  logic [WIDTH-1:0] maskReg;
  logic [WIDTH-1:0] statusReg;
  logic [WIDTH-1:0] keptBits;
  logic [WIDTH-1:0] newBits;

  always_comb begin
    keptBits = ctl.clearAll ? '0 : statusReg;
    newBits  = errPulse & maskReg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maskReg   <= ALL_ON;
      statusReg <= '0;
    end else begin
      if (ctl.loadMask) maskReg <= maskWrData;
      statusReg <= keptBits | newBits;
    end
  end

  assign statusData = statusReg;
  assign errFlagN   = ~(|statusReg);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (statusReg == '0 && maskReg == ALL_ON && errFlagN));

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.clearAll |=> ((statusReg & $past(statusReg)) == $past(statusReg)));

  // R3
  flag_low_chk: assert property (@(posedge clk) disable iff (rst)
    (|(errPulse & maskReg)) |=> !errFlagN);

  // R4
  clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.clearAll && errPulse == '0) |=> (statusReg == '0 && errFlagN));

  // R6
  pulse_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.clearAll |=> ((statusReg & $past(errPulse & maskReg)) == $past(errPulse & maskReg)));

  // R7
  masked_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((statusReg & ~$past(maskReg) & ~$past(statusReg)) == '0));
endmodule

// File: rtl/err_status_agg.sv
module err_status_agg
  import err_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [ERR_W-1:0] errPulse,
  input  logic             frameStart,
  input  logic             statusRead,
  input  logic             maskWrEn,
  input  logic [ERR_W-1:0] maskWrData,
  output logic [ERR_W-1:0] statusData,
  output logic             errFlagN
);
  errCtlT ctl;

  err_agg_ctrl ctrl_i (
    .frameStart(frameStart),
    .statusRead(statusRead),
    .maskWrEn  (maskWrEn),
    .ctl       (ctl)
  );

  err_agg_datapath #(.WIDTH(ERR_W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .errPulse  (errPulse),
    .maskWrData(maskWrData),
    .statusData(statusData),
    .errFlagN  (errFlagN)
  );
endmodule

// File: tb/err_status_agg_tb_top.sv
`timescale 1ns/1ps
module err_status_agg_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] errPulse;
  logic       frameStart;
  logic       statusRead;
  logic       maskWrEn;
  logic [7:0] maskWrData;
  logic [7:0] statusData;
  logic       errFlagN;

  int checks   = 0;
  int failures = 0;
  logic [7:0] expStatus;
  logic [7:0] expMask;

  always #2.5 clk = ~clk;

  err_status_agg dut_i (
    .clk(clk), .rst(rst), .errPulse(errPulse), .frameStart(frameStart),
    .statusRead(statusRead), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .statusData(statusData), .errFlagN(errFlagN)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, check read data before the rising edge,
  // then check word and flag after it.
  task automatic step(input logic [7:0] p, input logic fs, input logic rd,
                      input logic we, input logic [7:0] wd, input string req);
    @(negedge clk);
    errPulse = p; frameStart = fs; statusRead = rd; maskWrEn = we; maskWrData = wd;
    #1;
    if (rd) check({"R5 read value ", req}, statusData, expStatus);
    @(posedge clk);
    expStatus = ((fs || rd) ? 8'h00 : expStatus) | (p & expMask);
    if (we) expMask = wd;
    #1;
    check({"status ", req}, statusData, expStatus);
    check({"R3 flag ", req}, {7'b0, errFlagN}, {7'b0, (expStatus == 8'h00)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; errPulse = '0; frameStart = 0; statusRead = 0; maskWrEn = 0; maskWrData = '0;
    expStatus = 8'h00; expMask = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset status", statusData, 8'h00);
    check("R1 reset flag", {7'b0, errFlagN}, 8'h01);
    @(negedge clk); rst = 1'b0;

    // R9 / R2: every bit monitored by default, and held
    for (int i = 0; i < 8; i++) begin
      step(8'h01 << i, 0, 0, 0, 8'h00, "R9 default mask");
      step(8'h00, 0, 0, 0, 8'h00, "R2 hold");
      step(8'h00, 1, 0, 0, 8'h00, "R4 frame clear");
    end
    // R2 / R4: all pulse patterns, accumulate then frame clear
    for (int v = 0; v < 256; v++) begin
      step(v[7:0], 0, 0, 0, 8'h00, "R2 pattern");
      step(~v[7:0] & 8'h0F, 0, 0, 0, 8'h00, "R2 accumulate");
      step(8'h00, 1, 0, 0, 8'h00, "R4 frame clear");
    end
    // R5: read returns pre-clear word then clears
    for (int v = 1; v < 256; v += 7) begin
      step(v[7:0], 0, 0, 0, 8'h00, "R5 set");
      step(8'h00, 0, 1, 0, 8'h00, "R5 read clear");
    end
    // R6: pulses in the same cycle as a clear
    for (int v = 0; v < 256; v += 5) begin
      step(8'hFF, 0, 0, 0, 8'h00, "R6 prefill");
      step(v[7:0], 1, 0, 0, 8'h00, "R6 frame+pulse");
      step(~v[7:0], 0, 1, 0, 8'h00, "R6 read+pulse");
      step(8'h00, 1, 0, 0, 8'h00, "R6 drain");
    end
    // R7 / R8: single-bit masks, all pulses
    for (int i = 0; i < 8; i++) begin
      step(8'hFF, 1, 0, 1, 8'h01 << i, "R8 old mask in write cycle");
      step(8'h00, 1, 0, 0, 8'h00, "R8 clear");
      step(8'hFF, 0, 0, 0, 8'h00, "R8 new mask");
      step(8'h00, 1, 0, 0, 8'h00, "R7 clear");
      step(~(8'h01 << i), 0, 0, 0, 8'h00, "R7 masked ignored");
    end
    // R7: empty mask keeps flag high for every pattern
    step(8'h00, 1, 0, 1, 8'h00, "R7 zero mask");
    for (int v = 0; v < 256; v++) step(v[7:0], 0, 0, 0, 8'h00, "R7 zero mask pulses");
    // R1: reset mid-run restores mask to all ones
    step(8'h00, 0, 0, 1, 8'h3C, "R8 partial mask");
    step(8'h3C, 0, 0, 0, 8'h00, "R8 partial set");
    @(negedge clk); rst = 1'b1; errPulse = '0;
    @(posedge clk); #1;
    expStatus = 8'h00; expMask = 8'hFF;
    check("R1 reset clears status", statusData, 8'h00);
    check("R1 reset flag high", {7'b0, errFlagN}, 8'h01);
    @(negedge clk); rst = 1'b0;
    step(8'hC3, 0, 0, 0, 8'h00, "R1 mask all ones after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule